// File: doc/BRIEF.md
# Two-Phase Stack Processor Core

A small non-pipelined stack CPU with separate code and data memories. Each instruction is 9 bits wide and works on 32-bit data. The core spends two clock cycles on every instruction. In the FETCH phase it presents the program counter to a synchronous code memory. In the EXEC phase it decodes the returned word, updates its two stacks, the program counter and a temporary register, and drives the memory or peripheral-bus write strobes. The two phases alternate without pause: FETCH always goes to EXEC, and EXEC always goes back to FETCH.

Operands are implicit and live on a 16-entry data stack. The top and the entry below it are read every cycle. A separate 16-entry return stack holds call return addresses. Constants are built from 8-bit literal chunks: a run of consecutive literal words assembles one wide value. Every other instruction carries a 4-bit group field, and that field alone fixes how far the data stack pointer moves and whether a result is written. Data memory and the peripheral bus are both addressed by the top of stack.

Top module: `stk_core`

## Requirements
- R1: Reset puts the core in FETCH with program counter 0, both stack pointers 0 and the literal-chain flag clear, and it holds both write strobes low. After reset the phases alternate FETCH, EXEC, FETCH, and so on.
- R2: A word with bit 8 set is a literal with payload in bits 7..0. If the word before it was not a literal, the payload is pushed as a new entry, sign-extended from bit 7 to 32 bits.
- R3: A literal that directly follows a literal leaves the depth unchanged. It replaces the top with (old top << 8) | payload. Any non-literal word ends the chain.
- R4: A word with bit 8 clear carries its group in bits 7..4 and its opcode in bits 7..0. Each group fixes (pops, pushes): group 0 is (0,0), group 1 is (0,1), group 2 is (1,0), group 3 is (1,1), group 4 is (2,0) and group 5 is (2,1). Groups 6 to 15 leave the stacks untouched.
- R5: The program counter is held through FETCH. After EXEC of any word other than RET 0x01, JMP 0x20, CALL 0x21 and IF 0x40, it advances by exactly 1.
- R6: JMP (0x20) loads the program counter from bits 10..0 of the top. CALL (0x21) does the same and also pushes the program counter + 1 onto the return stack. RET (0x01) pops the return stack into the program counter.
- R7: IF (0x40) with stack ( flag target ) pops both. It jumps to the target when flag is 0; otherwise it falls through to the program counter + 1.
- R8: With stack ( a b ), b being the top, the following opcodes replace both entries with one result: 0x51 gives a+b, 0x52 gives a-b, 0x53 gives a&b, 0x54 gives a|b, 0x55 gives a^b and 0x59 gives the low 32 bits of a*b.
- R9: Opcode 0x56 pushes -1 when a equals b and 0 otherwise. 0x57 (a>b) and 0x58 (a<b) push -1 or 0 using a signed compare. Opcode 0x32 replaces the top with -1 when it is 0, and with 0 otherwise.
- R10: Opcode 0x33 shifts the top left by 1. Opcode 0x34 shifts it right by 1, filling with 0. Opcode 0x35 shifts it right by 1 and keeps the sign bit.
- R11: The stack words work as follows: DUP 0x13 gives ( a -- a a ), OVER 0x14 gives ( a b -- a b a ) and DROP 0x22 gives ( a -- ). NIP 0x50 gives ( a b -- b ) and saves a in a temporary register. TEMP> 0x10 pushes that register, so NIP followed by TEMP> swaps the top two entries.
- R12: DEPTH (0x11) pushes the number of data stack entries held before the push. RDEPTH (0x12) pushes the number of return stack entries.
- R13: Opcode 0x41 with stack ( d addr ) writes d to data memory at addr, raising the write enable for one cycle. Opcode 0x30 replaces addr with the memory word at addr.
- R14: OUTPORT (0x42) with stack ( d addr ) drives addr and d on the bus and raises the write strobe for exactly one cycle. INPORT (0x31) replaces addr with the bus read data for addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| code_addr | output | 11 | Program counter sent to code memory |
| code_data | input | 9 | Instruction word, valid one cycle after its address |
| mem_addr | output | 8 | Data memory address (low bits of top of stack) |
| mem_wdata | output | 32 | Data memory write data (second entry) |
| mem_we | output | 1 | Data memory write enable |
| mem_rdata | input | 32 | Data memory read data, registered by the memory |
| bus_addr | output | 8 | Peripheral address (low bits of top of stack) |
| bus_wdata | output | 32 | Peripheral write data (second entry) |
| bus_wr | output | 1 | One-cycle peripheral write strobe |
| bus_rdata | input | 32 | Peripheral read data |

## Verification
The assertions check the phase sequence on every cycle, together with the program counter holding through FETCH and stepping by one after non-branch words. They also check that the stack pointer moves only in EXEC, that a new literal grows the stack while a chained one does not, and that both strobes are single EXEC-cycle pulses. The bench scenarios are needed for the data itself: sign extension and literal chaining, each ALU and compare result including signed extremes, swap through the temporary register, depth counts, call and return ordering, the taken and untaken IF paths, and the round trip through data memory and the bus.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int INSTR_W = 9;

    typedef enum logic {
        ST_FETCH = 1'b0,
        ST_EXEC  = 1'b1
    } phase_t;

    localparam logic [7:0] OP_NOP     = 8'h00;
    localparam logic [7:0] OP_RET     = 8'h01;
    localparam logic [7:0] OP_TEMP    = 8'h10;
    localparam logic [7:0] OP_DEPTH   = 8'h11;
    localparam logic [7:0] OP_RDEPTH  = 8'h12;
    localparam logic [7:0] OP_DUP     = 8'h13;
    localparam logic [7:0] OP_OVER    = 8'h14;
    localparam logic [7:0] OP_JMP     = 8'h20;
    localparam logic [7:0] OP_CALL    = 8'h21;
    localparam logic [7:0] OP_DROP    = 8'h22;
    localparam logic [7:0] OP_LOAD    = 8'h30;
    localparam logic [7:0] OP_INPORT  = 8'h31;
    localparam logic [7:0] OP_NOT     = 8'h32;
    localparam logic [7:0] OP_SHL     = 8'h33;
    localparam logic [7:0] OP_SHR     = 8'h34;
    localparam logic [7:0] OP_SHRA    = 8'h35;
    localparam logic [7:0] OP_IF      = 8'h40;
    localparam logic [7:0] OP_STORE   = 8'h41;
    localparam logic [7:0] OP_OUTPORT = 8'h42;
    localparam logic [7:0] OP_NIP     = 8'h50;
    localparam logic [7:0] OP_ADD     = 8'h51;
    localparam logic [7:0] OP_SUB     = 8'h52;
    localparam logic [7:0] OP_AND     = 8'h53;
    localparam logic [7:0] OP_OR      = 8'h54;
    localparam logic [7:0] OP_XOR     = 8'h55;
    localparam logic [7:0] OP_EQ      = 8'h56;
    localparam logic [7:0] OP_GT      = 8'h57;
    localparam logic [7:0] OP_LT      = 8'h58;
    localparam logic [7:0] OP_MUL     = 8'h59;

    typedef struct packed {
        logic       is_lit;
        logic [7:0] payload;
        logic [7:0] opcode;
        logic [1:0] pops;
        logic       push;
    } stk_decoded_t;

endpackage

// File: rtl/stk_decode.sv
module stk_decode
    import stk_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output stk_decoded_t       dec
);

    always_comb begin
        dec.is_lit  = instr[INSTR_W-1];
        dec.payload = instr[7:0];
        dec.opcode  = instr[7:0];
        dec.pops    = 2'd0;
        dec.push    = 1'b0;
        if (!instr[INSTR_W-1]) begin
            unique case (instr[7:4])
                4'd0:    begin dec.pops = 2'd0; dec.push = 1'b0; end
                4'd1:    begin dec.pops = 2'd0; dec.push = 1'b1; end
                4'd2:    begin dec.pops = 2'd1; dec.push = 1'b0; end
                4'd3:    begin dec.pops = 2'd1; dec.push = 1'b1; end
                4'd4:    begin dec.pops = 2'd2; dec.push = 1'b0; end
                4'd5:    begin dec.pops = 2'd2; dec.push = 1'b1; end
                default: begin dec.pops = 2'd0; dec.push = 1'b0; end
            endcase
        end
    end

endmodule

// File: rtl/stk_regfile.sv
module stk_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    parameter int N_RD  = 2,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [PW-1:0]            waddr,
    input  logic [W-1:0]             wdata,
    input  logic [N_RD-1:0][PW-1:0]  raddr,
    output logic [N_RD-1:0][W-1:0]   rdata
);

    logic [W-1:0] cells [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_cell
            logic [W-1:0] cell_q;
            always_ff @(posedge clk) begin
                if (we && waddr == PW'(i)) begin
                    cell_q <= wdata;
                end
            end
            assign cells[i] = cell_q;
        end

        for (genvar r = 0; r < N_RD; r++) begin : g_rd
            assign rdata[r] = cells[raddr[r]];
        end
    endgenerate

endmodule

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] top,
    input  logic [DATA_W-1:0] second,
    input  logic [DATA_W-1:0] temp_val,
    input  logic [DATA_W-1:0] ds_count,
    input  logic [DATA_W-1:0] rs_count,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] result
);

    localparam logic [DATA_W-1:0] TRUE_W  = '1;
    localparam logic [DATA_W-1:0] FALSE_W = '0;

    always_comb begin
        unique case (opcode)
            OP_TEMP:   result = temp_val;
            OP_DEPTH:  result = ds_count;
            OP_RDEPTH: result = rs_count;
            OP_DUP:    result = top;
            OP_OVER:   result = second;
            OP_LOAD:   result = mem_rdata;
            OP_INPORT: result = bus_rdata;
            OP_NOT:    result = (top == '0) ? TRUE_W : FALSE_W;
            OP_SHL:    result = {top[DATA_W-2:0], 1'b0};
            OP_SHR:    result = {1'b0, top[DATA_W-1:1]};
            OP_SHRA:   result = {top[DATA_W-1], top[DATA_W-1:1]};
            OP_NIP:    result = top;
            OP_ADD:    result = second + top;
            OP_SUB:    result = second - top;
            OP_AND:    result = second & top;
            OP_OR:     result = second | top;
            OP_XOR:    result = second ^ top;
            OP_EQ:     result = (second == top) ? TRUE_W : FALSE_W;
            OP_GT:     result = ($signed(second) > $signed(top)) ? TRUE_W : FALSE_W;
            OP_LT:     result = ($signed(second) < $signed(top)) ? TRUE_W : FALSE_W;
            OP_MUL:    result = second * top;
            default:   result = FALSE_W;
        endcase
    end

endmodule

// File: rtl/stk_core.sv
module stk_core
    import stk_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PC_W     = 11,
    parameter int DS_DEPTH = 16,
    parameter int RS_DEPTH = 16,
    parameter int MEM_AW   = 8,
    parameter int BUS_AW   = 8
) (
    input  logic               clk,
    input  logic               rst,
    output logic [PC_W-1:0]    code_addr,
    input  logic [INSTR_W-1:0] code_data,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               mem_we,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [BUS_AW-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    output logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_rdata
);

    localparam int DS_PW = $clog2(DS_DEPTH);
    localparam int RS_PW = $clog2(RS_DEPTH);

    // phase state
    phase_t state_q, state_nx;
    logic   fetching;

    // architectural registers
    logic [PC_W-1:0]   pc_q, pc_nx;
    logic [DS_PW-1:0]  dsp_q, dsp_nx;
    logic [RS_PW-1:0]  rsp_q, rsp_nx;
    logic              prev_lit_q;
    logic [DATA_W-1:0] temp_q;

    // stack ports
    logic                        ds_we;
    logic [DS_PW-1:0]            ds_waddr;
    logic [DATA_W-1:0]           ds_wdata;
    logic [1:0][DS_PW-1:0]       ds_raddr;
    logic [1:0][DATA_W-1:0]      ds_rdata;
    logic [DATA_W-1:0]           top, second;

    logic                        rs_we;
    logic [RS_PW-1:0]            rs_waddr;
    logic [PC_W-1:0]             rs_wdata;
    logic [0:0][RS_PW-1:0]       rs_raddr;
    logic [0:0][PC_W-1:0]        rs_rdata;
    logic [PC_W-1:0]             rs_top;

    stk_decoded_t      dec;
    logic [DATA_W-1:0] alu_res;
    logic [DATA_W-1:0] lit_value;
    logic              temp_we;
    logic              mem_we_c, bus_wr_c;

    assign fetching = (state_q == ST_FETCH);

    stk_decode u_decode (
        .instr (code_data),
        .dec   (dec)
    );

    assign ds_raddr[0] = dsp_q;
    assign ds_raddr[1] = dsp_q - 1'b1;
    assign top         = ds_rdata[0];
    assign second      = ds_rdata[1];

    stk_regfile #(
        .W     (DATA_W),
        .DEPTH (DS_DEPTH),
        .N_RD  (2),
        .PW    (DS_PW)
    ) u_dstack (
        .clk   (clk),
        .we    (ds_we),
        .waddr (ds_waddr),
        .wdata (ds_wdata),
        .raddr (ds_raddr),
        .rdata (ds_rdata)
    );

    assign rs_raddr[0] = rsp_q;
    assign rs_top      = rs_rdata[0];

    stk_regfile #(
        .W     (PC_W),
        .DEPTH (RS_DEPTH),
        .N_RD  (1),
        .PW    (RS_PW)
    ) u_rstack (
        .clk   (clk),
        .we    (rs_we),
        .waddr (rs_waddr),
        .wdata (rs_wdata),
        .raddr (rs_raddr),
        .rdata (rs_rdata)
    );

    stk_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .opcode    (dec.opcode),
        .top       (top),
        .second    (second),
        .temp_val  (temp_q),
        .ds_count  (DATA_W'(dsp_q)),
        .rs_count  (DATA_W'(rsp_q)),
        .mem_rdata (mem_rdata),
        .bus_rdata (bus_rdata),
        .result    (alu_res)
    );

    // literal assembly: new push sign-extends, a chained literal shifts in a byte
    assign lit_value = prev_lit_q ? {top[DATA_W-9:0], dec.payload}
                                  : {{(DATA_W-8){dec.payload[7]}}, dec.payload};

    // state register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_FETCH: state_nx = ST_EXEC;
            ST_EXEC:  state_nx = ST_FETCH;
            default:  state_nx = ST_FETCH;
        endcase
    end

    // output and next-value process
    always_comb begin
        ds_we    = 1'b0;
        dsp_nx   = dsp_q;
        ds_waddr = dsp_q;
        ds_wdata = alu_res;
        rs_we    = 1'b0;
        rsp_nx   = rsp_q;
        rs_waddr = rsp_q + 1'b1;
        rs_wdata = pc_q + 1'b1;
        pc_nx    = pc_q + 1'b1;
        temp_we  = 1'b0;
        mem_we_c = 1'b0;
        bus_wr_c = 1'b0;
        if (!fetching) begin
            if (dec.is_lit) begin
                dsp_nx   = prev_lit_q ? dsp_q : dsp_q + 1'b1;
                ds_we    = 1'b1;
                ds_waddr = dsp_nx;
                ds_wdata = lit_value;
            end else begin
                dsp_nx   = dsp_q - DS_PW'(dec.pops) + DS_PW'(dec.push);
                ds_we    = dec.push;
                ds_waddr = dsp_nx;
                case (dec.opcode)
                    OP_JMP: begin
                        pc_nx = top[PC_W-1:0];
                    end
                    OP_CALL: begin
                        pc_nx  = top[PC_W-1:0];
                        rs_we  = 1'b1;
                        rsp_nx = rsp_q + 1'b1;
                    end
                    OP_RET: begin
                        pc_nx  = rs_top;
                        rsp_nx = rsp_q - 1'b1;
                    end
                    OP_IF: begin
                        if (second == '0) begin
                            pc_nx = top[PC_W-1:0];
                        end
                    end
                    OP_STORE:   mem_we_c = 1'b1;
                    OP_OUTPORT: bus_wr_c = 1'b1;
                    OP_NIP:     temp_we  = 1'b1;
                    default:    ;
                endcase
            end
        end
    end

    // datapath registers, updated at the end of EXEC
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q       <= '0;
            dsp_q      <= '0;
            rsp_q      <= '0;
            prev_lit_q <= 1'b0;
            temp_q     <= '0;
        end else if (!fetching) begin
            pc_q       <= pc_nx;
            dsp_q      <= dsp_nx;
            rsp_q      <= rsp_nx;
            prev_lit_q <= dec.is_lit;
            if (temp_we) begin
                temp_q <= second;
            end
        end
    end

    assign code_addr = pc_q;
    assign mem_addr  = top[MEM_AW-1:0];
    assign mem_wdata = second;
    assign mem_we    = mem_we_c;
    assign bus_addr  = top[BUS_AW-1:0];
    assign bus_wdata = second;
    assign bus_wr    = bus_wr_c;

endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk #(
    parameter int PC_W  = 11,
    parameter int DS_PW = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             fetching,
    input logic [PC_W-1:0]  code_addr,
    input logic [8:0]       code_data,
    input logic             prev_lit,
    input logic [DS_PW-1:0] dsp,
    input logic             bus_wr,
    input logic             mem_we
);

    logic exec_branch;
    assign exec_branch = !code_data[8] &&
        (code_data[7:0] == 8'h01 || code_data[7:0] == 8'h20 ||
         code_data[7:0] == 8'h21 || code_data[7:0] == 8'h40);

    assert_fetch_to_exec_R1: assert property (@(posedge clk) disable iff (rst)
        fetching |=> !fetching);

    assert_exec_to_fetch_R1: assert property (@(posedge clk) disable iff (rst)
        !fetching |=> fetching);

    assert_pc_hold_R5: assert property (@(posedge clk) disable iff (rst)
        fetching |=> code_addr == $past(code_addr));

    assert_pc_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!fetching && !exec_branch) |=> code_addr == PC_W'($past(code_addr) + 1'b1));

    assert_lit_push_R2: assert property (@(posedge clk) disable iff (rst)
        (!fetching && code_data[8] && !prev_lit) |=> dsp == DS_PW'($past(dsp) + 1'b1));

    assert_lit_chain_R3: assert property (@(posedge clk) disable iff (rst)
        (!fetching && code_data[8] && prev_lit) |=> $stable(dsp));

    assert_dsp_hold_R4: assert property (@(posedge clk) disable iff (rst)
        fetching |=> $stable(dsp));

    assert_store_exec_R13: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !fetching);

    assert_strobe_exec_R14: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> !fetching);

    assert_strobe_single_R14: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> !bus_wr);

endmodule

bind stk_core stk_core_chk #(
    .PC_W  (PC_W),
    .DS_PW (DS_PW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fetching  (fetching),
    .code_addr (code_addr),
    .code_data (code_data),
    .prev_lit  (prev_lit_q),
    .dsp       (dsp_q),
    .bus_wr    (bus_wr),
    .mem_we    (mem_we)
);

// File: tb/stk_core_tb.sv
module stk_core_tb;
    import stk_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] code_addr;
    logic [8:0]  code_q = 9'h000;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_we;
    logic [31:0] mem_rdata = 32'h0;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_wr;
    logic [31:0] bus_rdata;

    always #5 clk = ~clk;

    stk_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .code_addr (code_addr),
        .code_data (code_q),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rdata (bus_rdata)
    );

    logic [8:0]  rom  [256];
    logic [31:0] dmem [256];

    function automatic logic [31:0] inport_model(input logic [7:0] a);
        return {a, ~a, a ^ 8'h3C, 8'hC3};
    endfunction

    assign bus_rdata = inport_model(bus_addr);

    always @(posedge clk) begin
        code_q    <= rom[code_addr[7:0]];
        mem_rdata <= dmem[mem_addr];
        if (mem_we) dmem[mem_addr] <= mem_wdata;
    end

    // bus and memory observation, sampled at the falling edge
    int          log_n;
    logic [31:0] log_data [16];
    logic [7:0]  log_addr [16];
    int          we_pulses;
    int          double_strobes;
    logic        bus_wr_d;

    always @(negedge clk) begin
        if (rst) begin
            log_n          = 0;
            we_pulses      = 0;
            double_strobes = 0;
            bus_wr_d       = 1'b0;
        end else begin
            if (bus_wr) begin
                if (log_n < 16) begin
                    log_data[log_n] = bus_wdata;
                    log_addr[log_n] = bus_addr;
                end
                log_n = log_n + 1;
                if (bus_wr_d) double_strobes = double_strobes + 1;
            end
            if (mem_we) we_pulses = we_pulses + 1;
            bus_wr_d = bus_wr;
        end
    end

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int cyc    = 0;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000 && !done) begin
            done   = 1'b1;
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog R1: actual=%0d cycles expected=<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] log_at(input int i);
        return (i < log_n) ? log_data[i] : 32'hDEAD_DEAD;
    endfunction

    // program builder
    int ptr;

    task automatic prog_clear();
        for (int i = 0; i < 256; i++) rom[i] = 9'h000;
        ptr = 0;
    endtask

    task automatic emit(input logic [8:0] w);
        rom[ptr[7:0]] = w;
        ptr = ptr + 1;
    endtask

    task automatic op(input logic [7:0] o);
        emit({1'b0, o});
    endtask

    task automatic push_small(input logic [7:0] v);
        emit(9'h000);
        emit({1'b1, v});
    endtask

    task automatic push_val(input logic [31:0] v);
        emit(9'h000);
        emit({1'b1, v[31:24]});
        emit({1'b1, v[23:16]});
        emit({1'b1, v[15:8]});
        emit({1'b1, v[7:0]});
    endtask

    task automatic out_port(input logic [7:0] p);
        push_small(p);
        op(OP_OUTPORT);
    endtask

    task automatic end_prog();
        int l;
        l = ptr + 1;
        push_small(l[7:0]);
        op(OP_JMP);
    endtask

    task automatic run_prog();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        repeat (220) @(posedge clk);
        #2;
    endtask

    function automatic logic [31:0] bin_model(input logic [7:0] o, input logic [31:0] a, input logic [31:0] b);
        case (o)
            OP_ADD: return a + b;
            OP_SUB: return a - b;
            OP_AND: return a & b;
            OP_OR:  return a | b;
            OP_XOR: return a ^ b;
            OP_EQ:  return (a == b) ? 32'hFFFF_FFFF : 32'h0;
            OP_GT:  return ($signed(a) > $signed(b)) ? 32'hFFFF_FFFF : 32'h0;
            OP_LT:  return ($signed(a) < $signed(b)) ? 32'hFFFF_FFFF : 32'h0;
            OP_MUL: return a * b;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] un_model(input logic [7:0] o, input logic [31:0] a);
        case (o)
            OP_NOT:  return (a == 0) ? 32'hFFFF_FFFF : 32'h0;
            OP_SHL:  return a << 1;
            OP_SHR:  return a >> 1;
            OP_SHRA: return {a[31], a[31:1]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string bin_tag(input logic [7:0] o);
        return (o == OP_EQ || o == OP_GT || o == OP_LT) ? "R9 compare" : "R8 arith";
    endfunction

    task automatic test_bin(input logic [7:0] o, input logic [31:0] a, input logic [31:0] b);
        prog_clear();
        push_val(a); push_val(b); op(o); out_port(8'd2); end_prog();
        run_prog();
        chk(bin_tag(o), log_at(0), bin_model(o, a, b));
    endtask

    task automatic test_un(input logic [7:0] o, input logic [31:0] a);
        prog_clear();
        push_val(a); op(o); out_port(8'd2); end_prog();
        run_prog();
        chk((o == OP_NOT) ? "R9 not" : "R10 shift", log_at(0), un_model(o, a));
    endtask

    logic [7:0] bin_ops [9] = '{OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_EQ, OP_GT, OP_LT, OP_MUL};
    logic [7:0] un_ops  [4] = '{OP_NOT, OP_SHL, OP_SHR, OP_SHRA};

    initial begin
        logic [31:0] a, b, seed_v;
        seed_v = $urandom(32'd20240611);
        for (int i = 0; i < 256; i++) dmem[i] = 32'h0;
        prog_clear();

        // R1 reset state
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset pc", {21'h0, code_addr}, 32'h0);
        chk("R1 reset bus_wr", {31'h0, bus_wr}, 32'h0);
        chk("R1 reset mem_we", {31'h0, mem_we}, 32'h0);

        // R1/R5 phase alternation seen on the program counter
        @(negedge clk) rst = 1'b0;
        for (int k = 0; k < 8; k++) begin
            chk("R5 pc sequence", {21'h0, code_addr}, k / 2);
            @(negedge clk);
        end

        // R12 / R1 counts after reset
        prog_clear(); op(OP_DEPTH); out_port(8'd1); op(OP_RDEPTH); out_port(8'd1); end_prog();
        run_prog();
        chk("R12 depth after reset", log_at(0), 32'd0);
        chk("R12 rdepth after reset", log_at(1), 32'd0);

        // R2 sign extension
        prog_clear(); push_small(8'h80); out_port(8'd1); push_small(8'h7F); out_port(8'd1); end_prog();
        run_prog();
        chk("R2 negative literal", log_at(0), 32'hFFFF_FF80);
        chk("R2 positive literal", log_at(1), 32'h0000_007F);

        // R3 chaining
        prog_clear();
        emit(9'h000); emit(9'h101); emit(9'h102); out_port(8'd1);
        emit(9'h000); emit(9'h1FF); emit(9'h112); out_port(8'd1);
        push_small(8'd5); push_small(8'd6); out_port(8'd1); out_port(8'd1);
        end_prog();
        run_prog();
        chk("R3 chain positive", log_at(0), 32'h0000_0102);
        chk("R3 chain negative", log_at(1), 32'hFFFF_FF12);
        chk("R3 separated top", log_at(2), 32'd6);
        chk("R3 separated next", log_at(3), 32'd5);
        chk("R3 write count", log_n, 32'd4);

        // R3 random full-width values
        for (int i = 0; i < 4; i++) begin
            a = $urandom;
            prog_clear(); push_val(a); out_port(8'd1); end_prog();
            run_prog();
            chk("R3 random literal", log_at(0), a);
        end

        // R4 unknown group leaves the stack
        a = $urandom;
        prog_clear(); push_small(8'd9); push_val(a); op(8'h65); op(8'hF3); out_port(8'd1); out_port(8'd1); end_prog();
        run_prog();
        chk("R4 unknown group top", log_at(0), a);
        chk("R4 unknown group next", log_at(1), 32'd9);

        // R8 / R9 directed corners
        test_bin(OP_EQ,  32'h1234_5678, 32'h1234_5678);
        test_bin(OP_EQ,  32'h1234_5678, 32'h1234_5679);
        test_bin(OP_GT,  32'hFFFF_FFFF, 32'h0000_0001);
        test_bin(OP_LT,  32'hFFFF_FFFF, 32'h0000_0001);
        test_bin(OP_GT,  32'h7FFF_FFFF, 32'h8000_0000);
        test_bin(OP_LT,  32'h0000_0005, 32'h0000_0005);
        test_bin(OP_SUB, 32'h0000_0003, 32'h0000_0005);
        test_bin(OP_MUL, 32'hFFFF_FFFE, 32'h0000_0003);

        // R8 / R9 random
        for (int i = 0; i < 30; i++) begin
            logic [7:0] o;
            o = bin_ops[$urandom % 9];
            a = $urandom;
            b = (i % 5 == 0) ? a : $urandom;
            test_bin(o, a, b);
        end

        // R9 / R10 unary, directed and random
        test_un(OP_NOT, 32'h0);
        test_un(OP_NOT, 32'h0000_0100);
        test_un(OP_SHRA, 32'h8000_0000);
        test_un(OP_SHR, 32'h8000_0001);
        test_un(OP_SHL, 32'h8000_0001);
        for (int i = 0; i < 8; i++) test_un(un_ops[$urandom % 4], $urandom);

        // R11 stack words
        a = $urandom; b = $urandom;
        prog_clear(); push_val(a); push_val(b); op(OP_OVER);
        out_port(8'd1); out_port(8'd1); out_port(8'd1); end_prog();
        run_prog();
        chk("R11 over copy", log_at(0), a);
        chk("R11 over top", log_at(1), b);
        chk("R11 over bottom", log_at(2), a);

        prog_clear(); push_val(a); op(OP_DUP); out_port(8'd1); out_port(8'd1);
        push_val(a); push_val(b); op(OP_DROP); out_port(8'd1); end_prog();
        run_prog();
        chk("R11 dup first", log_at(0), a);
        chk("R11 dup second", log_at(1), a);
        chk("R11 drop", log_at(2), a);

        prog_clear(); push_val(a); push_val(b); op(OP_NIP); op(OP_TEMP);
        out_port(8'd1); out_port(8'd1); end_prog();
        run_prog();
        chk("R11 swap top", log_at(0), a);
        chk("R11 swap next", log_at(1), b);

        // R12 depth
        prog_clear(); push_small(8'd1); push_small(8'd2); push_small(8'd3); op(OP_DEPTH);
        out_port(8'd1); end_prog();
        run_prog();
        chk("R12 depth three", log_at(0), 32'd3);

        // R6 jump skips code
        a = $urandom;
        prog_clear(); push_small(8'd40); op(OP_JMP); push_small(8'h55); out_port(8'd9); end_prog();
        ptr = 40; push_val(a); out_port(8'd3); end_prog();
        run_prog();
        chk("R6 jmp count", log_n, 32'd1);
        chk("R6 jmp target", log_at(0), a);

        // R6 / R12 call and return
        prog_clear(); push_small(8'd100); op(OP_CALL);
        push_val(32'h1111_2222); out_port(8'd7); end_prog();
        ptr = 100; op(OP_RDEPTH); out_port(8'd6);
        push_val(32'hABCD_0123); out_port(8'd5); op(OP_RET);
        run_prog();
        chk("R12 rdepth in call", log_at(0), 32'd1);
        chk("R6 call body", log_at(1), 32'hABCD_0123);
        chk("R6 return path", log_at(2), 32'h1111_2222);
        chk("R6 call count", log_n, 32'd3);

        // R7 conditional branch, both ways
        for (int t = 0; t < 2; t++) begin
            prog_clear(); push_val((t == 0) ? 32'h0 : 32'h0000_0100); push_small(8'd40); op(OP_IF);
            push_small(8'h22); out_port(8'd2); end_prog();
            ptr = 40; push_small(8'h33); out_port(8'd2); end_prog();
            run_prog();
            chk((t == 0) ? "R7 if taken" : "R7 if fall through", log_at(0), (t == 0) ? 32'h33 : 32'h22);
            chk("R7 if count", log_n, 32'd1);
        end

        // R13 memory store and fetch
        a = $urandom;
        prog_clear(); push_val(a); push_small(8'd17); op(OP_STORE);
        push_small(8'd17); op(OP_LOAD); out_port(8'd4);
        push_small(8'd18); op(OP_LOAD); out_port(8'd4); end_prog();
        run_prog();
        chk("R13 fetch after store", log_at(0), a);
        chk("R13 untouched neighbour", log_at(1), 32'h0);
        chk("R13 write pulses", we_pulses, 32'd1);

        // R14 bus read and write strobe
        prog_clear(); push_small(8'd77); op(OP_INPORT); out_port(8'd12); end_prog();
        run_prog();
        chk("R14 inport data", log_at(0), inport_model(8'd77));
        chk("R14 outport addr", {24'h0, log_addr[0]}, 32'd12);
        chk("R14 strobe count", log_n, 32'd1);
        chk("R14 strobe width", double_strobes, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule